// File: doc/BRIEF.md
# SPI Master Register Front End

This block is the processor-facing half of a full-duplex SPI master. A small 32-bit register bus reaches a data port, two control registers, a status register and a clock-divider register. Words written to the data port are queued in a transmit FIFO and handed to a separate serial engine. Words the engine receives are queued in a receive FIFO and popped by reads of the same data port. The serial engine does the bit timing and drives the pins. This block only holds configuration, buffers words and reports state.

Software turns the block on through the enable bit and picks the configuration: loopback, which of two chip selects to use, bit order for each direction, word length and clock divider. The engine sees all of these on dedicated level outputs. Software then streams words and watches the status flags. Underrun and overrun are sticky until software clears them. Both FIFOs can be emptied at any time with flush bits that clear themselves.

Top module: `spictl_front`

## Requirements
- R1: Register byte offsets are 0x00 data, 0x04 control 0, 0x08 control 1, 0x0C status and 0x18 divider. Any other offset reads 0, and writes to it have no effect.
- R2: A data write pushes the word into the transmit FIFO. While enabled, the engine is offered the words in write order on the transmit handshake, one per cycle in which valid and ready are both high.
- R3: A data read returns the oldest received word and removes it. A data read while the receive FIFO is empty returns 0 and removes nothing.
- R4: Each FIFO holds 128 words. Status bit 5 is set when the transmit FIFO holds 128 words, and a data write at that point is dropped.
- R5: Control 0 bit 15 is enable, bit 10 loopback, bit 6 chip-select-1 choice, bit 19 LSB-first transmit and bit 17 LSB-first receive. Each bit reads back as written and drives its own configuration output.
- R6: Writing 1 to control 0 bit 2 empties the transmit FIFO, and writing 1 to bit 1 empties the receive FIFO. In both cases the FIFO is empty one cycle after the write, and both bits always read 0.
- R7: Control 1 bits 7:3 hold the word length minus 2 (words of 2 to 32 bits). The field reads back and appears on the frame-length output, and all other bits of control 1 read 0.
- R8: Status bit 7 (end) is 1 when the transmit FIFO is empty and the engine is idle. Bit 6 mirrors engine busy, bit 4 is 1 when the receive FIFO is empty, and bit 2 is 1 when the receive FIFO holds 64 words or more.
- R9: A received word that arrives while the receive FIFO is full sets status bit 0 (overrun) and is dropped.
- R10: The engine asking for a word while enabled with an empty transmit FIFO sets status bit 1 (underrun).
- R11: Underrun and overrun stay set until a status write carries 0 in that bit. A status write carrying 1 leaves the flag unchanged.
- R12: While the enable bit is 0, the transmit valid and receive ready outputs stay low. Received words are ignored, and no underrun is raised.
- R13: The divider register keeps its low 8 bits, reads them back and drives the divider output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| eng_tx_valid | output | 1 | Transmit word offered to the engine |
| eng_tx_data | output | 32 | Transmit word |
| eng_tx_ready | input | 1 | Engine takes or asks for a transmit word |
| eng_rx_valid | input | 1 | Engine presents a received word |
| eng_rx_data | input | 32 | Received word |
| eng_rx_ready | output | 1 | Block accepts received words |
| eng_busy | input | 1 | Engine is shifting |
| cfg_enable | output | 1 | Controller enabled |
| cfg_loopback | output | 1 | Internal loopback request |
| cfg_cs_sel | output | 1 | 1 selects chip select 1 |
| cfg_tx_lsb | output | 1 | Transmit LSB first |
| cfg_rx_lsb | output | 1 | Receive LSB first |
| cfg_frame_len | output | 5 | Word length minus 2 |
| cfg_div | output | 8 | Serial clock divider |

## Verification
A wrong FIFO pointer or count appears at once in the order or value of data-port reads and transmit-handshake words. A wrong count also moves the full, empty and half-full status bits at the exact word where they should change, and the bench checks them at those counts. A flag that fails to set or fails to stick shows in the first status read after the event or after a clearing write. A flush that never clears, or that clears late, shows as missing or stale words one cycle after the control write.

// File: rtl/spictl_pkg.sv
package spictl_pkg;
   localparam int ADDR_W = 5;
   localparam int BUS_W  = 32;

   localparam logic [ADDR_W-1:0] OFS_DATA = 5'h00;
   localparam logic [ADDR_W-1:0] OFS_CTL0 = 5'h04;
   localparam logic [ADDR_W-1:0] OFS_CTL1 = 5'h08;
   localparam logic [ADDR_W-1:0] OFS_STAT = 5'h0C;
   localparam logic [ADDR_W-1:0] OFS_DIV  = 5'h18;

   localparam int C0_TXLSB = 19;
   localparam int C0_RXLSB = 17;
   localparam int C0_EN    = 15;
   localparam int C0_LOOP  = 10;
   localparam int C0_CSSEL = 6;
   localparam int C0_TXFL  = 2;
   localparam int C0_RXFL  = 1;

   localparam int C1_FLEN_LO = 3;
   localparam int FLEN_W     = 5;

   localparam int ST_END    = 7;
   localparam int ST_BUSY   = 6;
   localparam int ST_TFULL  = 5;
   localparam int ST_REMPTY = 4;
   localparam int ST_RHALF  = 2;
   localparam int ST_UNDR   = 1;
   localparam int ST_OVER   = 0;

   typedef struct packed {
      logic enable;
      logic loopback;
      logic cs_sel;
      logic tx_lsb;
      logic rx_lsb;
   } ctl0_t;
endpackage

// File: rtl/spictl_fifo.sv
module spictl_fifo #(
   parameter int W          = 32,
   parameter int DEPTH      = 128,
   parameter bit ZERO_EMPTY = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           clr,
   input  logic                           push,
   input  logic [W-1:0]                   din,
   input  logic                           pop,
   output logic [W-1:0]                   dout,
   output logic                           full,
   output logic                           empty,
   output logic [$clog2(DEPTH+1)-1:0]     count
);
   localparam int AW    = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH+1);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("spictl_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          do_push, do_pop;

   assign full    = (count == CNT_W'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else if (clr) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !clr) mem[wp] <= din;
   end

   if (ZERO_EMPTY) begin : g_zero_head
      assign dout = empty ? '0 : mem[rp];
   end else begin : g_raw_head
      assign dout = mem[rp];
   end

   // R4
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));
   // R6
   flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count == '0));
   // R2
   push_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !full && !pop && !clr) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/spictl_flags.sv
module spictl_flags (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       set_under,
   input  logic       set_over,
   input  logic       wr_stat,
   input  logic [1:0] wr_bits,
   output logic       under,
   output logic       over
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         under <= 1'b0;
         over  <= 1'b0;
      end else begin
         if (set_under)                 under <= 1'b1;
         else if (wr_stat && !wr_bits[1]) under <= 1'b0;
         if (set_over)                  over  <= 1'b1;
         else if (wr_stat && !wr_bits[0]) over  <= 1'b0;
      end
   end

   // R11
   over_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (over && !(wr_stat && !wr_bits[0])) |=> over);
   // R11
   under_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (under && !(wr_stat && !wr_bits[1])) |=> under);
endmodule

// File: rtl/spictl_front.sv
module spictl_front
   import spictl_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int FIFO_DEPTH = 128,
   parameter int DIV_W      = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_sel,
   input  logic                bus_wr,
   input  logic [4:0]          bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   output logic                eng_tx_valid,
   output logic [DATA_W-1:0]   eng_tx_data,
   input  logic                eng_tx_ready,
   input  logic                eng_rx_valid,
   input  logic [DATA_W-1:0]   eng_rx_data,
   output logic                eng_rx_ready,
   input  logic                eng_busy,
   output logic                cfg_enable,
   output logic                cfg_loopback,
   output logic                cfg_cs_sel,
   output logic                cfg_tx_lsb,
   output logic                cfg_rx_lsb,
   output logic [4:0]          cfg_frame_len,
   output logic [DIV_W-1:0]    cfg_div
);
   localparam int CNT_W = $clog2(FIFO_DEPTH+1);
   localparam int HALF  = FIFO_DEPTH / 2;

   if (DATA_W != BUS_W) begin : g_bad_width
      $error("spictl_front: DATA_W must equal the bus width");
   end
   if (DIV_W < 1 || DIV_W > BUS_W) begin : g_bad_div
      $error("spictl_front: DIV_W out of range");
   end

   ctl0_t             ctl0;
   logic [FLEN_W-1:0] flen;
   logic [DIV_W-1:0]  div_q;
   logic              flush_tx_q, flush_rx_q;
   logic              wr_data, wr_c0, wr_c1, wr_st, wr_dv, rd_data;
   logic              tx_full, tx_empty, rx_full, rx_empty;
   logic [CNT_W-1:0]  tx_cnt, rx_cnt;
   logic [DATA_W-1:0] rx_head;
   logic              under, over, set_under, set_over;

   assign wr_data = bus_sel && bus_wr && (bus_addr == OFS_DATA);
   assign wr_c0   = bus_sel && bus_wr && (bus_addr == OFS_CTL0);
   assign wr_c1   = bus_sel && bus_wr && (bus_addr == OFS_CTL1);
   assign wr_st   = bus_sel && bus_wr && (bus_addr == OFS_STAT);
   assign wr_dv   = bus_sel && bus_wr && (bus_addr == OFS_DIV);
   assign rd_data = bus_sel && !bus_wr && (bus_addr == OFS_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl0       <= '0;
         flen       <= '0;
         div_q      <= '0;
         flush_tx_q <= 1'b0;
         flush_rx_q <= 1'b0;
      end else begin
         flush_tx_q <= wr_c0 && bus_wdata[C0_TXFL];
         flush_rx_q <= wr_c0 && bus_wdata[C0_RXFL];
         if (wr_c0) begin
            ctl0.enable   <= bus_wdata[C0_EN];
            ctl0.loopback <= bus_wdata[C0_LOOP];
            ctl0.cs_sel   <= bus_wdata[C0_CSSEL];
            ctl0.tx_lsb   <= bus_wdata[C0_TXLSB];
            ctl0.rx_lsb   <= bus_wdata[C0_RXLSB];
         end
         if (wr_c1) flen  <= bus_wdata[C1_FLEN_LO +: FLEN_W];
         if (wr_dv) div_q <= bus_wdata[DIV_W-1:0];
      end
   end

   spictl_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH), .ZERO_EMPTY(1'b0)) i_tx_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (flush_tx_q),
      .push  (wr_data),
      .din   (bus_wdata),
      .pop   (eng_tx_valid && eng_tx_ready),
      .dout  (eng_tx_data),
      .full  (tx_full),
      .empty (tx_empty),
      .count (tx_cnt)
   );

   spictl_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH), .ZERO_EMPTY(1'b1)) i_rx_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (flush_rx_q),
      .push  (eng_rx_valid && eng_rx_ready),
      .din   (eng_rx_data),
      .pop   (rd_data),
      .dout  (rx_head),
      .full  (rx_full),
      .empty (rx_empty),
      .count (rx_cnt)
   );

   assign eng_tx_valid = ctl0.enable && !tx_empty;
   assign eng_rx_ready = ctl0.enable;
   assign set_under    = ctl0.enable && eng_tx_ready && tx_empty;
   assign set_over     = eng_rx_valid && eng_rx_ready && rx_full;

   spictl_flags i_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_under (set_under),
      .set_over  (set_over),
      .wr_stat   (wr_st),
      .wr_bits   (bus_wdata[1:0]),
      .under     (under),
      .over      (over)
   );

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         OFS_DATA: bus_rdata = rx_head;
         OFS_CTL0: begin
            bus_rdata[C0_EN]    = ctl0.enable;
            bus_rdata[C0_LOOP]  = ctl0.loopback;
            bus_rdata[C0_CSSEL] = ctl0.cs_sel;
            bus_rdata[C0_TXLSB] = ctl0.tx_lsb;
            bus_rdata[C0_RXLSB] = ctl0.rx_lsb;
         end
         OFS_CTL1: bus_rdata[C1_FLEN_LO +: FLEN_W] = flen;
         OFS_STAT: begin
            bus_rdata[ST_END]    = tx_empty && !eng_busy;
            bus_rdata[ST_BUSY]   = eng_busy;
            bus_rdata[ST_TFULL]  = tx_full;
            bus_rdata[ST_REMPTY] = rx_empty;
            bus_rdata[ST_RHALF]  = (rx_cnt >= CNT_W'(HALF));
            bus_rdata[ST_UNDR]   = under;
            bus_rdata[ST_OVER]   = over;
         end
         OFS_DIV:  bus_rdata[DIV_W-1:0] = div_q;
         default:  bus_rdata = '0;
      endcase
   end

   assign cfg_enable    = ctl0.enable;
   assign cfg_loopback  = ctl0.loopback;
   assign cfg_cs_sel    = ctl0.cs_sel;
   assign cfg_tx_lsb    = ctl0.tx_lsb;
   assign cfg_rx_lsb    = ctl0.rx_lsb;
   assign cfg_frame_len = flen;
   assign cfg_div       = div_q;

   // R9
   overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_rx_valid && eng_rx_ready && rx_full) |=> over);
   // R10
   underrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_enable && eng_tx_ready && tx_empty) |=> under);
   // R9
   drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full && !rd_data && !flush_rx_q) |=> rx_full);
endmodule

// File: tb/test_spictl_front.sv
module test_spictl_front;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        eng_tx_valid;
   logic [31:0] eng_tx_data;
   logic        eng_tx_ready = 1'b0;
   logic        eng_rx_valid = 1'b0;
   logic [31:0] eng_rx_data = '0;
   logic        eng_rx_ready;
   logic        eng_busy = 1'b0;
   logic        cfg_enable, cfg_loopback, cfg_cs_sel, cfg_tx_lsb, cfg_rx_lsb;
   logic [4:0]  cfg_frame_len;
   logic [7:0]  cfg_div;

   int compared = 0;
   int mismatched = 0;

   always #2 clk = ~clk;

   spictl_front i_spictl_front (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data),
      .eng_tx_ready(eng_tx_ready), .eng_rx_valid(eng_rx_valid),
      .eng_rx_data(eng_rx_data), .eng_rx_ready(eng_rx_ready),
      .eng_busy(eng_busy), .cfg_enable(cfg_enable),
      .cfg_loopback(cfg_loopback), .cfg_cs_sel(cfg_cs_sel),
      .cfg_tx_lsb(cfg_tx_lsb), .cfg_rx_lsb(cfg_rx_lsb),
      .cfg_frame_len(cfg_frame_len), .cfg_div(cfg_div)
   );

   // {addr, write data, expected readback}
   localparam logic [71:0] VEC [10] = '{
      {8'h04, 32'h000A8440, 32'h000A8440},   // R5
      {8'h04, 32'h000A8446, 32'h000A8440},   // R6 flush bits read 0
      {8'h04, 32'hFFFFFFFF, 32'h000A8440},   // R5
      {8'h04, 32'h00000000, 32'h00000000},   // R5
      {8'h08, 32'hFFFFFFFF, 32'h000000F8},   // R7
      {8'h08, 32'h00000050, 32'h00000050},   // R7
      {8'h18, 32'hFFFFFFFF, 32'h000000FF},   // R13
      {8'h18, 32'h00000012, 32'h00000012},   // R13
      {8'h10, 32'hFFFFFFFF, 32'h00000000},   // R1
      {8'h14, 32'hFFFFFFFF, 32'h00000000}    // R1
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic rx_word(input logic [31:0] d);
      @(negedge clk);
      eng_rx_valid = 1'b1; eng_rx_data = d;
      @(negedge clk);
      eng_rx_valid = 1'b0;
   endtask

   task automatic tx_take();
      @(negedge clk);
      eng_tx_ready = 1'b1;
      @(negedge clk);
      eng_tx_ready = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state: end and rx-empty set (R8)
      bus_read(5'h0C, r); check("R8 reset status", r, 32'h90);
      bus_read(5'h04, r); check("R5 reset ctl0", r, 32'h0);
      bus_read(5'h00, r); check("R3 reset data", r, 32'h0);

      for (int i = 0; i < 10; i++) begin
         bus_write(VEC[i][68:64], VEC[i][63:32]);
         bus_read(VEC[i][68:64], r);
         check("R1/R5/R7/R13 table", r, VEC[i][31:0]);
      end
      check("R7 frame len out", {27'b0, cfg_frame_len}, 32'd10);
      check("R13 div out", {24'b0, cfg_div}, 32'h12);

      // R5 config outputs
      bus_write(5'h04, 32'h000A8440);
      check("R5 cfg outputs", {27'b0, cfg_enable, cfg_loopback, cfg_cs_sel, cfg_tx_lsb, cfg_rx_lsb}, 32'h1F);
      bus_write(5'h04, 32'h00020000);
      check("R5 rx_lsb only", {27'b0, cfg_enable, cfg_loopback, cfg_cs_sel, cfg_tx_lsb, cfg_rx_lsb}, 32'h01);

      // R2 ordered transmit
      bus_write(5'h04, 32'h00008000);
      bus_write(5'h00, 32'hA1); bus_write(5'h00, 32'hB2); bus_write(5'h00, 32'hC3);
      check("R2 word0", eng_tx_data, 32'hA1); check("R2 valid", {31'b0, eng_tx_valid}, 1);
      tx_take(); check("R2 word1", eng_tx_data, 32'hB2);
      tx_take(); check("R2 word2", eng_tx_data, 32'hC3);
      tx_take(); check("R2 drained", {31'b0, eng_tx_valid}, 0);
      bus_read(5'h0C, r); check("R8 end after drain", r, 32'h90);

      // R10 underrun and R11 sticky clear
      tx_take();
      bus_read(5'h0C, r); check("R10 underrun", r, 32'h92);
      bus_write(5'h0C, 32'hFFFFFFFF);
      bus_read(5'h0C, r); check("R11 write 1 keeps", r, 32'h92);
      bus_write(5'h0C, 32'h0);
      bus_read(5'h0C, r); check("R11 write 0 clears", r, 32'h90);

      // R3 receive order and empty read
      rx_word(32'h11); rx_word(32'h22);
      bus_read(5'h00, r); check("R3 rx0", r, 32'h11);
      bus_read(5'h00, r); check("R3 rx1", r, 32'h22);
      bus_read(5'h00, r); check("R3 empty read", r, 32'h0);
      rx_word(32'h33);
      bus_read(5'h00, r); check("R3 no pop on empty", r, 32'h33);

      // R8 half mark, R4 depth, R9 overrun
      for (int i = 0; i < 63; i++) rx_word(i);
      bus_read(5'h0C, r); check("R8 half at 63", r & 32'h4, 32'h0);
      rx_word(63);
      bus_read(5'h0C, r); check("R8 half at 64", r & 32'h4, 32'h4);
      for (int i = 64; i < 128; i++) rx_word(i);
      bus_read(5'h0C, r); check("R9 no overrun at 128", r & 32'h1, 32'h0);
      rx_word(32'h999);
      bus_read(5'h0C, r); check("R9 overrun set", r & 32'h11, 32'h1);
      for (int i = 0; i < 128; i++) begin
         bus_read(5'h00, r);
         if (r !== 32'(i)) check("R9 rx order", r, 32'(i));
      end
      compared++;
      bus_read(5'h00, r); check("R9 dropped word absent", r, 32'h0);
      bus_write(5'h0C, 32'h0);

      // R4 transmit full and drop
      bus_write(5'h04, 32'h0);
      for (int i = 0; i < 129; i++) bus_write(5'h00, 32'(i + 16'h100));
      bus_read(5'h0C, r); check("R4 tx full", r & 32'h20, 32'h20);
      bus_write(5'h04, 32'h00008000);
      for (int i = 0; i < 128; i++) begin
         if (eng_tx_data !== 32'(i + 16'h100)) check("R4 tx order", eng_tx_data, 32'(i + 16'h100));
         tx_take();
      end
      compared++;
      check("R4 extra write dropped", {31'b0, eng_tx_valid}, 0);

      // R6 flushes
      bus_write(5'h04, 32'h0);
      bus_write(5'h00, 32'h5); bus_write(5'h00, 32'h6);
      bus_read(5'h0C, r); check("R6 tx loaded", r & 32'h80, 32'h0);
      bus_write(5'h04, 32'h00000004);
      bus_read(5'h0C, r); check("R6 tx flushed", r & 32'h80, 32'h80);
      bus_read(5'h04, r); check("R6 flush reads 0", r, 32'h0);
      bus_write(5'h04, 32'h00008000);
      rx_word(32'h7); rx_word(32'h8);
      bus_write(5'h04, 32'h00008002);
      bus_read(5'h0C, r); check("R6 rx flushed", r & 32'h10, 32'h10);
      bus_read(5'h00, r); check("R6 rx flushed data", r, 32'h0);

      // R12 disabled behaviour
      bus_write(5'h04, 32'h0);
      bus_write(5'h00, 32'h44);
      check("R12 tx_valid low", {31'b0, eng_tx_valid}, 0);
      check("R12 rx_ready low", {31'b0, eng_rx_ready}, 0);
      rx_word(32'h55);
      bus_read(5'h0C, r); check("R12 rx ignored", r & 32'h10, 32'h10);
      bus_write(5'h04, 32'h00000004);
      tx_take();
      bus_read(5'h0C, r); check("R12 no underrun", r & 32'h2, 32'h0);

      // R8 busy and end
      eng_busy = 1'b1;
      bus_read(5'h0C, r); check("R8 busy", r & 32'hC0, 32'h40);
      eng_busy = 1'b0;
      bus_read(5'h0C, r); check("R8 idle", r & 32'hC0, 32'h80);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule